// File: doc/BRIEF.md
# Fine-Grain Thread Selector

This block sits in front of the fetch/issue multiplexer of a single-issue, in-order core that interleaves four hardware threads. In every clock cycle it looks at each thread's ready flag and its four stall causes: cache miss, resource conflict, pending trap or interrupt, and refetch after a taken branch. It then names the thread that issues in that cycle, using a one-hot select and a valid flag. The choice can move to a different thread on every cycle. No branch prediction is assumed. A thread whose branch was taken is held out while its new stream is fetched, and the other threads fill its slots.

Selection normally rotates among the threads, starting after the thread that issued last. Threads that cannot issue are skipped. A thread that has just come out of a stall carries a priority mark, and that mark outranks the rotation until the thread issues. When several marked threads compete, the rotation order from the last issuer decides among them. The select is combinational from the current inputs and the block's registered state: the rotation pointer, the per-thread stall history and the per-thread priority marks.

Top module: `fg_thread_sel`

## Requirements
- R1: A thread is eligible only when its ready bit is 1 and none of its miss, conflict, trap and refetch bits is 1; each of those four causes alone blocks the thread.
- R2: `sel_o` is one-hot or all zero, bit t meaning thread t, and `valid_o` is 1 exactly when `sel_o` is non-zero.
- R3: Without priority marks, the selected thread is the first eligible thread found by scanning upward from the last issued thread, wrapping from 3 to 0; after reset the last issued thread is taken to be thread 3, so thread 0 is scanned first.
- R4: Stalled threads are skipped in the rotation; a thread whose refetch bit is 1 is held out while other eligible threads take the slots.
- R5: A thread resumes when at least one of its four causes was 1 in the previous cycle and all four are 0 now. Once it has resumed and is eligible, it is chosen ahead of the normal rotation.
- R6: When several eligible threads carry priority marks, the first of them found by scanning upward from the last issued thread is selected.
- R7: A priority mark set on resumption persists, even while the thread is not ready, and clears in the cycle the thread issues.
- R8: When no thread is eligible, `valid_o` is 0, `sel_o` is 0, and the last-issued pointer does not change.
- R9: The select reflects the current cycle's inputs in that same cycle, and can change thread every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | NT | Per-thread ready flag |
| miss_i | input | NT | Per-thread cache miss stall |
| conflict_i | input | NT | Per-thread resource conflict stall |
| trap_i | input | NT | Per-thread trap/interrupt pending stall |
| refetch_i | input | NT | Per-thread taken-branch refetch stall |
| sel_o | output | NT | One-hot issuing thread |
| valid_o | output | 1 | A thread issues this cycle |

## Verification
Resume priority and rotation are both decided in every cycle. The interesting cases are the cycles where they disagree. The bench stalls a thread while the others rotate, then releases it in the cycle where the rotation would pick a different thread, and checks that the released thread wins. The next cycle's choice is then checked to confirm that the mark cleared and the rotation continues from the resumed thread. Two threads are also released together, and a release is made while the thread is not ready. In both cases the marks must be served in rotation order and must outlast the not-ready cycles.

// File: rtl/fg_tsel_pkg.sv
package fg_tsel_pkg;
  localparam int unsigned NT_DEFAULT = 4;

  typedef struct packed {
    logic miss;
    logic conflict;
    logic trap;
    logic refetch;
  } stall_cause_t;
endpackage

// File: rtl/fg_tsel_rr.sv
// Rotating first-found picker: scans upward from last+1.
module fg_tsel_rr #(
  parameter int unsigned NT = 4,
  localparam int unsigned PW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT-1:0] req_i,
  input  logic [PW-1:0] last_i,
  output logic [NT-1:0] gnt_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = 1; i <= int'(NT); i++) begin
      int idx;
      idx = (int'(last_i) + i) % int'(NT);
      if (req_i[idx] && (gnt_o == '0)) gnt_o[idx] = 1'b1;
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/fg_tsel_track.sv
// Stall history and resume-priority marks.
module fg_tsel_track #(
  parameter int unsigned NT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NT-1:0] stall_i,
  input  logic [NT-1:0] issued_i,
  output logic [NT-1:0] mark_o
);
  logic [NT-1:0] stalled_q;
  logic [NT-1:0] mark_q;
  logic [NT-1:0] resume;

  assign resume = stalled_q & ~stall_i;
  assign mark_o = mark_q | resume;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stalled_q <= '0;
      mark_q    <= '0;
    end else begin
      stalled_q <= stall_i;
      mark_q    <= mark_o & ~issued_i;
    end
  end
endmodule

// File: rtl/fg_thread_sel.sv
module fg_thread_sel
  import fg_tsel_pkg::*;
#(
  parameter int unsigned NT = NT_DEFAULT,
  localparam int unsigned PW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NT-1:0] ready_i,
  input  logic [NT-1:0] miss_i,
  input  logic [NT-1:0] conflict_i,
  input  logic [NT-1:0] trap_i,
  input  logic [NT-1:0] refetch_i,
  output logic [NT-1:0] sel_o,
  output logic          valid_o
);
  stall_cause_t [NT-1:0] cause;
  logic [NT-1:0] stall, elig, mark, pri_req;
  logic [NT-1:0] gnt_pri, gnt_rr;
  logic          any_pri, any_rr;
  logic [PW-1:0] last_q, sel_idx;

  for (genvar t = 0; t < NT; t++) begin : g_cause
    assign cause[t] = '{miss: miss_i[t], conflict: conflict_i[t],
                        trap: trap_i[t], refetch: refetch_i[t]};
    assign stall[t] = |cause[t];
  end

  assign elig    = ready_i & ~stall;
  assign pri_req = mark & elig;

  fg_tsel_track #(.NT(NT)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (stall),
    .issued_i(sel_o),
    .mark_o  (mark)
  );

  fg_tsel_rr #(.NT(NT)) u_pri (
    .req_i (pri_req),
    .last_i(last_q),
    .gnt_o (gnt_pri),
    .any_o (any_pri)
  );

  fg_tsel_rr #(.NT(NT)) u_rot (
    .req_i (elig),
    .last_i(last_q),
    .gnt_o (gnt_rr),
    .any_o (any_rr)
  );

  assign sel_o   = any_pri ? gnt_pri : gnt_rr;
  assign valid_o = any_rr;

  always_comb begin
    sel_idx = '0;
    for (int t = 0; t < int'(NT); t++)
      if (sel_o[t]) sel_idx = PW'(t);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= PW'(NT - 1);
    else if (valid_o) last_q <= sel_idx;
  end
endmodule

// File: rtl/fg_thread_sel_chk.sv
module fg_thread_sel_chk #(
  parameter int unsigned NT = 4,
  localparam int unsigned PW = (NT > 1) ? $clog2(NT) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NT-1:0] ready_i,
  input logic [NT-1:0] miss_i,
  input logic [NT-1:0] conflict_i,
  input logic [NT-1:0] trap_i,
  input logic [NT-1:0] refetch_i,
  input logic [NT-1:0] sel_o,
  input logic          valid_o
);
  logic [NT-1:0] blk, ok, was_blk, mk_q, mk_now, prio;
  logic [PW-1:0] lst_q;
  logic [NT-1:0] exp_rr;

  assign blk    = miss_i | conflict_i | trap_i | refetch_i;
  assign ok     = ready_i & ~blk;
  assign mk_now = mk_q | (was_blk & ~blk);
  assign prio   = mk_now & ok;

  always_comb begin
    exp_rr = '0;
    for (int k = 0; k < int'(NT); k++) begin
      int j;
      j = (int'(lst_q) + 1 + k) % int'(NT);
      if (ok[j] && exp_rr == '0) exp_rr[j] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      was_blk <= '0;
      mk_q    <= '0;
      lst_q   <= PW'(NT - 1);
    end else begin
      was_blk <= blk;
      mk_q    <= mk_now & ~sel_o;
      for (int t = 0; t < int'(NT); t++)
        if (sel_o[t]) lst_q <= PW'(t);
    end
  end

  a_r2_onehot_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o) && (valid_o == (sel_o != '0)));

  a_r1_sel_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o & ~ok) == '0);

  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok == '0) |-> !valid_o);

  a_r5_prio_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio != '0) |-> ((sel_o & prio) != '0));

  a_r3_rotation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio == '0) |-> (sel_o == exp_rr));
endmodule

bind fg_thread_sel fg_thread_sel_chk #(.NT(NT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready_i),
  .miss_i    (miss_i),
  .conflict_i(conflict_i),
  .trap_i    (trap_i),
  .refetch_i (refetch_i),
  .sel_o     (sel_o),
  .valid_o   (valid_o)
);

// File: tb/fg_thread_sel_tb.sv
module fg_thread_sel_tb;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] ready_i = '0, miss_i = '0, conflict_i = '0, trap_i = '0, refetch_i = '0;
  logic [NT-1:0] sel_o;
  logic          valid_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fg_thread_sel #(.NT(NT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ready_i(ready_i), .miss_i(miss_i),
    .conflict_i(conflict_i), .trap_i(trap_i), .refetch_i(refetch_i),
    .sel_o(sel_o), .valid_o(valid_o)
  );

  task automatic check(input logic ev, input logic [NT-1:0] es, input string req);
    n_chk++;
    if (valid_o !== ev || sel_o !== es) begin
      n_bad++;
      $display("FAIL %s: valid=%b sel=%b expected valid=%b sel=%b", req, valid_o, sel_o, ev, es);
    end
  endtask

  // drive at negedge, sample 1 ns later, state updates at next posedge
  task automatic step(input logic [NT-1:0] rdy, ms, cf, tp, rf,
                      input logic ev, input logic [NT-1:0] es, input string req);
    @(negedge clk);
    ready_i = rdy; miss_i = ms; conflict_i = cf; trap_i = tp; refetch_i = rf;
    #1;
    check(ev, es, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ready_i = '0; miss_i = '0; conflict_i = '0; trap_i = '0; refetch_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1 check(1'b0, 4'b0000, "R8 reset idle");
  endtask

  task automatic t_rotation();
    do_reset();
    step(4'hF, 0, 0, 0, 0, 1, 4'b0001, "R3 first t0");
    step(4'hF, 0, 0, 0, 0, 1, 4'b0010, "R9 R3 t1");
    step(4'hF, 0, 0, 0, 0, 1, 4'b0100, "R3 t2");
    step(4'hF, 0, 0, 0, 0, 1, 4'b1000, "R3 t3");
    step(4'hF, 0, 0, 0, 0, 1, 4'b0001, "R3 wrap t0");
  endtask

  task automatic t_skip();
    do_reset();
    step(4'hF, 4'b0010, 0, 0, 0, 1, 4'b0001, "R4 t0");
    step(4'hF, 4'b0010, 0, 0, 0, 1, 4'b0100, "R4 skip missing t1");
    step(4'hF, 4'b0010, 0, 0, 0, 1, 4'b1000, "R4 t3");
    step(4'hF, 4'b0010, 0, 0, 0, 1, 4'b0001, "R4 wrap t0");
  endtask

  task automatic t_causes();
    do_reset();
    step(4'b0001, 4'b0001, 0, 0, 0, 0, 4'b0000, "R1 miss blocks");
    step(4'b0001, 0, 4'b0001, 0, 0, 0, 4'b0000, "R1 conflict blocks");
    step(4'b0001, 0, 0, 4'b0001, 0, 0, 4'b0000, "R1 trap blocks");
    step(4'b0001, 0, 0, 0, 4'b0001, 0, 4'b0000, "R1 refetch blocks");
    step(4'b0000, 0, 0, 0, 0, 0, 4'b0000, "R1 not ready");
  endtask

  task automatic t_idle_hold();
    do_reset();
    step(4'hF, 0, 0, 0, 0, 1, 4'b0001, "R8 t0 issues");
    step(4'h0, 0, 0, 0, 0, 0, 4'b0000, "R8 idle");
    step(4'h0, 0, 0, 0, 0, 0, 4'b0000, "R8 idle again");
    step(4'hF, 0, 0, 0, 0, 1, 4'b0010, "R8 pointer held");
  endtask

  task automatic t_branch_resume();
    do_reset();
    step(4'hF, 0, 0, 0, 0,       1, 4'b0001, "R4 t0 issues");
    step(4'hF, 0, 0, 0, 4'b0001, 1, 4'b0010, "R4 refetch fills t1");
    step(4'hF, 0, 0, 0, 4'b0001, 1, 4'b0100, "R4 refetch fills t2");
    step(4'hF, 0, 0, 0, 0,       1, 4'b0001, "R5 resumed t0 beats t3");
    step(4'hF, 0, 0, 0, 0,       1, 4'b0010, "R7 mark cleared");
  endtask

  task automatic t_dual_resume();
    do_reset();
    step(4'hF, 4'b0010, 0, 4'b1000, 0, 1, 4'b0001, "R6 t0");
    step(4'hF, 4'b0010, 0, 4'b1000, 0, 1, 4'b0100, "R6 t2");
    step(4'hF, 0, 0, 0, 0, 1, 4'b1000, "R6 resumers ordered t3");
    step(4'hF, 0, 0, 0, 0, 1, 4'b0010, "R6 R7 t1 mark kept");
    step(4'hF, 0, 0, 0, 0, 1, 4'b0100, "R7 marks gone");
  endtask

  task automatic t_mark_not_ready();
    do_reset();
    step(4'b1111, 0, 4'b0100, 0, 0, 1, 4'b0001, "R7 t0");
    step(4'b1011, 0, 0, 0, 0, 1, 4'b0010, "R7 resume while not ready");
    step(4'b1011, 0, 0, 0, 0, 1, 4'b1000, "R7 still not ready");
    step(4'b1111, 0, 0, 0, 0, 1, 4'b0100, "R7 mark kept beats t0");
    step(4'b1111, 0, 0, 0, 0, 1, 4'b1000, "R7 mark cleared");
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_rotation();
    t_skip();
    t_causes();
    t_idle_hold();
    t_branch_resume();
    t_dual_resume();
    t_mark_not_ready();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule